// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Skip Flush

This block drives the fetch address of a small processor that uses 14-bit instruction words, with fetch one stage ahead of execute. Every cycle the decoder gives it the class of the instruction now executing and that instruction's operands. The operands are a skip verdict, an 11-bit absolute address, a 9-bit signed offset and the working register value. The decoder also gives a flag. The flag marks an indirect access made through a pointer register whose top bit is set.

From these inputs the block computes the next fetch address. It raises `flush` for a cycle whose execute slot must run as a NOP. That happens after a taken skip and after any change to the program counter. It raises `stall` for the extra cycle that a slow indirect access needs. The block also holds a 16-entry return stack and a latch for the upper program counter bits.

`flush` and `stall` each mark a cycle in which the presented instruction is void. The block ignores its inputs in those cycles.

Top module: `insn_seq`

## Requirements
- R1: After reset, `pc` is 0 and both `flush` and `stall` are low.
- R2: An executing plain instruction (class 0) without the slow-indirect flag advances `pc` by one and raises neither `flush` nor `stall`.
- R3: An executing skip (class 1) with `skip_hit` high advances `pc` by one and makes the next cycle a flush cycle. With `skip_hit` low, a skip behaves as a plain instruction.
- R4: Jump (class 2) and call (class 3) load `pc` with the latch's top PC_W-11 bits followed by `imm11`. The next cycle is a flush cycle.
- R5: Relative branch (class 4) loads `pc` with its current value plus the sign-extended `off9`, and the next cycle is a flush cycle. The current value is the address of the instruction after the branch.
- R6: Branch by register (class 5) loads `pc` with its current value plus the zero-extended `wreg`, and the next cycle is a flush cycle.
- R7: Call through register (class 6) loads `pc` with {latch, `wreg`}, and the next cycle is a flush cycle.
- R8: Both calls (class 3 and class 6) push the current `pc` onto the stack. Return (class 7) pops the stack into `pc` and makes the next cycle a flush cycle. The stack pointer wraps modulo 16 with no error.
- R9: A plain instruction or a skip that executes with `ind_hi` high holds `pc` for that cycle, and the next cycle is a stall cycle. If that skip was taken, the flush cycle follows the stall cycle. `ind_hi` has no effect on the other classes.
- R10: In a flush or stall cycle, `pc` advances by one and all inputs are ignored. This covers the class, `lat_we`, the stack and the skip verdict. `flush` and `stall` are never high together.
- R11: `lat_we` loads `lat_din` into the upper-bits latch only in an executing cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_cls | input | 3 | Executing instruction class: 0 plain, 1 skip, 2 jump, 3 call, 4 relative branch, 5 branch by register, 6 call through register, 7 return |
| skip_hit | input | 1 | Skip condition true |
| ind_hi | input | 1 | Indirect access through a pointer whose top bit is set |
| imm11 | input | 11 | Absolute target low bits |
| off9 | input | 9 | Signed relative branch offset |
| wreg | input | 8 | Working register value |
| lat_we | input | 1 | Load the upper-bits latch |
| lat_din | input | PC_W-8 | Latch load value |
| pc | output | PC_W | Fetch address |
| flush | output | 1 | This cycle's execute slot is a NOP |
| stall | output | 1 | Extra cycle for a slow indirect access |

## Verification
The bench uses the defaults PC_W=15 and STK_DEPTH=16. With these, a 7-bit latch feeds both absolute forms, and the stack is shallow enough that a directed run of eighteen calls and eighteen returns wraps the pointer in both directions. The 15-bit address is wide enough that random 9-bit negative offsets and register branches wrap across address zero. Random classes arrive in every cycle, including flush and stall cycles. This checks that void cycles ignore their inputs, and that skips combined with the slow-indirect flag order the stall before the flush.

// File: rtl/insn_seq.sv
module insn_seq #(
  parameter int PC_W      = 15,
  parameter int STK_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_cls,
  input  logic             skip_hit,
  input  logic             ind_hi,
  input  logic [10:0]      imm11,
  input  logic [8:0]       off9,
  input  logic [7:0]       wreg,
  input  logic             lat_we,
  input  logic [PC_W-9:0]  lat_din,
  output logic [PC_W-1:0]  pc,
  output logic             flush,
  output logic             stall
);
  localparam int LAT_W = PC_W - 8;
  localparam int SP_W  = $clog2(STK_DEPTH);
  localparam logic [2:0] C_PLAIN = 3'd0, C_SKIP = 3'd1, C_JMP = 3'd2, C_CALL = 3'd3,
                         C_BRA = 3'd4, C_BRW = 3'd5, C_CALLW = 3'd6, C_RET = 3'd7;

  logic [PC_W-1:0]  pc_q, tgt;
  logic [LAT_W-1:0] lat_q;
  logic [SP_W-1:0]  sp_q;
  logic [PC_W-1:0]  stk [STK_DEPTH];
  logic             fl_q, st_q, pend_q;

  wire exec     = !fl_q && !st_q;
  wire data_op  = (op_cls == C_PLAIN) || (op_cls == C_SKIP);
  wire slow     = exec && data_op && ind_hi;
  wire skip_tk  = exec && (op_cls == C_SKIP) && skip_hit;
  wire ctrl     = exec && !data_op;
  wire push     = exec && ((op_cls == C_CALL) || (op_cls == C_CALLW));
  wire pop      = exec && (op_cls == C_RET);

  always_comb begin
    case (op_cls)
      C_JMP, C_CALL: tgt = {lat_q[LAT_W-1:3], imm11};
      C_BRA:         tgt = pc_q + {{(PC_W-9){off9[8]}}, off9};
      C_BRW:         tgt = pc_q + {{(PC_W-8){1'b0}}, wreg};
      C_CALLW:       tgt = {lat_q, wreg};
      C_RET:         tgt = stk[sp_q - 1'b1];
      default:       tgt = pc_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      fl_q   <= 1'b0;
      st_q   <= 1'b0;
      pend_q <= 1'b0;
      sp_q   <= '0;
      lat_q  <= '0;
    end else if (!exec) begin
      pc_q   <= pc_q + 1'b1;
      fl_q   <= st_q && pend_q;
      st_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (slow)      pc_q <= pc_q;
      else if (ctrl) pc_q <= tgt;
      else           pc_q <= pc_q + 1'b1;
      st_q   <= slow;
      pend_q <= slow && skip_tk;
      fl_q   <= ctrl || (skip_tk && !slow);
      if (lat_we) lat_q <= lat_din;
      if (push)   sp_q <= sp_q + 1'b1;
      else if (pop) sp_q <= sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && push) stk[sp_q] <= pc_q;

  assign pc    = pc_q;
  assign flush = fl_q;
  assign stall = st_q;

  // R2
  plain_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall && op_cls == C_PLAIN && !ind_hi) |=> (pc == $past(pc) + 1'b1) && !flush && !stall);
  // R3
  skip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall && op_cls == C_SKIP && skip_hit && !ind_hi) |=> flush && !stall);
  // R9
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall && (op_cls == C_PLAIN || op_cls == C_SKIP) && ind_hi) |=> stall && $stable(pc));
  // R10
  void_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || stall) |=> (pc == $past(pc) + 1'b1) && !stall);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(flush && stall));
  // R8
  ret_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !stall && op_cls == C_RET) |=> flush);
endmodule

// File: tb/insn_seq_tb.sv
module insn_seq_tb;
  localparam int PC_W = 15;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op_cls = '0;
  logic skip_hit = 0, ind_hi = 0, lat_we = 0;
  logic [10:0] imm11 = '0;
  logic [8:0] off9 = '0;
  logic [7:0] wreg = '0;
  logic [PC_W-9:0] lat_din = '0;
  logic [PC_W-1:0] pc;
  logic flush, stall;

  insn_seq u_dut (.clk(clk), .rst_n(rst_n), .op_cls(op_cls), .skip_hit(skip_hit), .ind_hi(ind_hi),
    .imm11(imm11), .off9(off9), .wreg(wreg), .lat_we(lat_we), .lat_din(lat_din),
    .pc(pc), .flush(flush), .stall(stall));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [PC_W-1:0] m_pc, m_stk [16];
  logic m_fl, m_st, m_pend;
  logic [3:0] m_sp;
  logic [PC_W-9:0] m_lat;
  string tag;

  function automatic logic [PC_W-1:0] exp_tgt(input logic [2:0] c, input logic [PC_W-1:0] p,
      input logic [PC_W-9:0] l, input logic [10:0] a, input logic [8:0] o, input logic [7:0] w,
      input logic [PC_W-1:0] top);
    case (c)
      3'd2, 3'd3: return {l[PC_W-9:3], a};
      3'd4:       return p + {{(PC_W-9){o[8]}}, o};
      3'd5:       return p + {{(PC_W-8){1'b0}}, w};
      3'd6:       return {l, w};
      3'd7:       return top;
      default:    return p + 1'b1;
    endcase
  endfunction

  task automatic check();
    nchk++;
    if (pc !== m_pc || flush !== m_fl || stall !== m_st) begin
      nfail++;
      $display("FAIL %s: pc/flush/stall %h/%b/%b expected %h/%b/%b", tag, pc, flush, stall, m_pc, m_fl, m_st);
    end
  endtask

  task automatic model_step();
    logic ex, dop, slw, sk;
    ex = !m_fl && !m_st;
    if (!ex) begin
      m_pc = m_pc + 1'b1; m_fl = m_st && m_pend; m_st = 0; m_pend = 0;
      tag = "R10";
      return;
    end
    dop = (op_cls <= 3'd1);
    slw = dop && ind_hi;
    sk  = (op_cls == 3'd1) && skip_hit;
    if (slw)      begin m_pc = m_pc; tag = "R9"; end
    else if (!dop) begin
      m_pc = exp_tgt(op_cls, m_pc, m_lat, imm11, off9, wreg, m_stk[m_sp - 4'd1]);
      case (op_cls)
        3'd2: tag = "R4"; 3'd3: tag = "R4"; 3'd4: tag = "R5"; 3'd5: tag = "R6";
        3'd6: tag = "R7"; default: tag = "R8";
      endcase
    end else begin m_pc = m_pc + 1'b1; tag = sk ? "R3" : "R2"; end
    if (op_cls == 3'd3 || op_cls == 3'd6) begin m_stk[m_sp] = pc; m_sp = m_sp + 1'b1; if (op_cls == 3'd6) tag = "R7"; end
    else if (op_cls == 3'd7) begin m_sp = m_sp - 1'b1; tag = "R8"; end
    m_st = slw; m_pend = slw && sk; m_fl = !dop || (sk && !slw);
    if (lat_we) begin m_lat = lat_din; if (tag == "R2") tag = "R11"; end
  endtask

  task automatic cyc(input logic [2:0] c, input logic sh, input logic ih, input logic lw);
    op_cls = c; skip_hit = sh; ind_hi = ih; lat_we = lw;
    imm11 = 11'($urandom); off9 = 9'($urandom); wreg = 8'($urandom); lat_din = 7'($urandom);
    model_step();
    @(negedge clk);
    check();
  endtask

  bit done = 0;
  initial begin
    void'($urandom(32'd1234));
    m_pc = '0; m_fl = 0; m_st = 0; m_pend = 0; m_sp = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    tag = "R1"; check();
    rst_n = 1'b1;
    // R11 then R4: load latch and jump
    cyc(3'd0, 0, 0, 1); cyc(3'd2, 0, 0, 0); cyc(3'd0, 0, 0, 0);
    // R3 taken and not taken, R9 slow skip
    cyc(3'd1, 1, 0, 0); cyc(3'd0, 0, 0, 0); cyc(3'd1, 0, 0, 0);
    cyc(3'd1, 1, 1, 0); cyc(3'd0, 0, 0, 0); cyc(3'd0, 0, 0, 0); cyc(3'd0, 0, 0, 0);
    // R8 stack wrap: 18 calls, 18 returns
    for (int i = 0; i < 18; i++) begin cyc(3'd3, 0, 0, 0); cyc(3'd0, 0, 0, 0); end
    for (int i = 0; i < 18; i++) begin cyc(3'd7, 0, 0, 0); cyc(3'd0, 0, 0, 0); end
    // random mix, inputs also random in void cycles
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      logic [2:0] c = (r < 6) ? 3'd0 : (r < 10) ? 3'd1 : 3'($urandom_range(2, 7));
      cyc(c, 1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule